// File: doc/BRIEF.md
# Processor Subsystem Power-Down Sequencer

This block takes a running processor subsystem down to an unpowered, held-in-reset state in a fixed and safe order. A one-cycle stop pulse starts the sequence. The block first parks the processor's bus port: it raises a halt request and holds it until the halt controller acknowledges. It then removes the core clock and raises the I/O clamp. Next it drops the two memory retention controls and switches the memory banks off one at a time, lowest index first, with a long wait after each bank so that the supply current falls in steps.

After the banks, the block raises the memory retention clamp, opens the head switch and waits for it to settle. It then polls the head switch's reset-acknowledge status with a bounded number of retries. On success it asserts the subsystem reset, then the core reset, and reports done. If the retries run out, it reports an error and leaves both resets released. If the halt controller reports that the port did not reach idle, the sequence still runs to the end and a sticky warning is raised.

All wait lengths, the retry limit and the bank count are parameters counted in clock cycles. The integrator chooses them from the clock frequency, for example 1 ms between banks and between polls, and about 1 µs of settle time.

Top module: `pwrdn_seq`

## Requirements
- R1: A stop pulse seen in the idle state raises `halt_req_o` in the next cycle. `halt_req_o` stays high until the cycle in which `halt_ack_i` is sampled high, and it is low in the cycle after that.
- R2: If `halt_idle_i` is low in the cycle in which the acknowledge is taken, `warn_o` rises and stays high until reset. The power-down sequence continues regardless.
- R3: `core_clk_en_o` falls two cycles after the acknowledge cycle. `io_clamp_o` rises one cycle after that. `l2_stby_n_o` falls one cycle later, and `slp_ret_n_o` falls one cycle after that.
- R4: The bits of `bank_pwr_o` clear one at a time in ascending order, starting with bit 0. Bit 0 clears one cycle after `slp_ret_n_o` falls, and each later bit clears BANK_WAIT+1 cycles after the previous one.
- R5: `mem_clamp_o` rises BANK_WAIT+1 cycles after the highest bank clears. `head_sw_on_o` falls one cycle after that.
- R6: The first sample of `hsw_ack_i` is taken SETTLE_WAIT cycles after the first cycle in which `head_sw_on_o` is low. Further samples follow every POLL_GAP+1 cycles, up to POLL_MAX samples in total. A low sample ends the polling, and `sub_rst_o` rises two cycles after that sample cycle.
- R7: If all POLL_MAX samples are high, `err_o` rises in the cycle after the last sample. `sub_rst_o`, `core_rst_o` and `done_o` then stay low. `done_o` and `err_o` are never high together.
- R8: `core_rst_o` rises one cycle after `sub_rst_o`. `done_o` rises in the same cycle as `core_rst_o`.
- R9: A stop pulse that arrives while a sequence is running is ignored. No second halt request is raised, and the timing of the running sequence does not change.
- R10: A stop pulse in the done or error state restarts the sequence. In the next cycle `done_o` and `err_o` are low and `halt_req_o` is high.
- R11: After reset the outputs show a powered subsystem. Core clock enabled, both retention controls high, all banks on, head switch on. Clamps, resets, halt request, done, error and warning are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | One-cycle request to power down |
| halt_ack_i | input | 1 | Halt controller acknowledge |
| halt_idle_i | input | 1 | Bus port reached idle, valid with the acknowledge |
| hsw_ack_i | input | 1 | Head switch reset-acknowledge status, low when off |
| halt_req_o | output | 1 | Bus port halt request |
| core_clk_en_o | output | 1 | Core clock enable |
| io_clamp_o | output | 1 | I/O clamp |
| l2_stby_n_o | output | 1 | L2 data standby, active low |
| slp_ret_n_o | output | 1 | Sleep retention, active low |
| bank_pwr_o | output | NUM_BANKS | Per-bank memory power switch |
| mem_clamp_o | output | 1 | Memory retention clamp |
| head_sw_on_o | output | 1 | Head switch enable |
| sub_rst_o | output | 1 | Subsystem reset |
| core_rst_o | output | 1 | Core reset |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 1 | Head switch acknowledge never cleared |
| warn_o | output | 1 | Sticky: halt finished without port idle |

## Verification
The assertions assume three things about the inputs. The halt controller raises its acknowledge only while the request is high, with the idle status valid alongside it. The head-switch status is a level that is sampled only in poll cycles. `stop_i` is a one-cycle pulse.

The bench's halt responder raises the acknowledge a fixed number of cycles after the request and drops it once the request falls. The head-switch status is driven from a count of cycles since the switch opened, so that it clears at exactly the first poll, the last poll, or never. The stop line is only ever pulsed for a single cycle.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_HALT,
      ST_CLK_OFF,
      ST_IO_CLAMP,
      ST_L2_OFF,
      ST_RET_OFF,
      ST_BANK_OFF,
      ST_BANK_WAIT,
      ST_MEM_CLAMP,
      ST_HSW_OFF,
      ST_SETTLE,
      ST_POLL,
      ST_POLL_WAIT,
      ST_SUB_RST,
      ST_CORE_RST,
      ST_DONE,
      ST_FAIL
   } seq_st_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pwrdn_seq_timer.sv
module pwrdn_seq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [CW-1:0] len_i,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= len_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == CW'(1));

   AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1); // R4
endmodule

// File: rtl/pwrdn_seq_banks.sv
module pwrdn_seq_banks #(
   parameter int NB = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic [IW-1:0] idx_i,
   output logic [NB-1:0] bank_o
);
   for (genvar i = 0; i < NB; i++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          bank_o[i] <= 1'b1;
         else if (clr_i && idx_i == IW'(i))   bank_o[i] <= 1'b0;
      end
   end

   AST_BANK_NEVER_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_o & ~$past(bank_o)) == '0); // R4
   AST_BANK_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      bank_o != $past(bank_o) |-> bank_o == ($past(bank_o) & ($past(bank_o) - NB'(1)))); // R4
endmodule

// File: rtl/pwrdn_seq_ctrl.sv
module pwrdn_seq_ctrl
   import pwrdn_seq_pkg::*;
#(
   parameter int NUM_BANKS   = 20,
   parameter int BANK_WAIT   = 100000,
   parameter int SETTLE_WAIT = 100,
   parameter int POLL_GAP    = 100000,
   parameter int POLL_MAX    = 200,
   parameter int CW          = 17,
   parameter int IW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop_i,
   input  logic          halt_ack_i,
   input  logic          halt_idle_i,
   input  logic          hsw_ack_i,
   input  logic          tmr_done_i,
   output logic          tmr_start_o,
   output logic [CW-1:0] tmr_len_o,
   output logic          bank_clr_o,
   output logic [IW-1:0] bank_idx_o,
   output logic          halt_req_o,
   output logic          core_clk_en_o,
   output logic          io_clamp_o,
   output logic          l2_stby_n_o,
   output logic          slp_ret_n_o,
   output logic          mem_clamp_o,
   output logic          head_sw_on_o,
   output logic          sub_rst_o,
   output logic          core_rst_o,
   output logic          done_o,
   output logic          err_o,
   output logic          warn_o
);
   localparam int PW = $clog2(POLL_MAX + 1);
   localparam logic [IW-1:0] LAST_BANK = IW'(NUM_BANKS - 1);
   localparam logic [PW-1:0] LAST_POLL = PW'(POLL_MAX - 1);

   seq_st_e st_q, st_d;
   logic [PW-1:0] polls_q;
   logic accept;

   assign accept = stop_i && (st_q == ST_IDLE || st_q == ST_DONE || st_q == ST_FAIL);

   always_comb begin
      st_d        = st_q;
      tmr_start_o = 1'b0;
      tmr_len_o   = '0;
      bank_clr_o  = 1'b0;
      case (st_q)
         ST_IDLE, ST_DONE, ST_FAIL: if (accept) st_d = ST_HALT;
         ST_HALT:      if (halt_ack_i) st_d = ST_CLK_OFF;
         ST_CLK_OFF:   st_d = ST_IO_CLAMP;
         ST_IO_CLAMP:  st_d = ST_L2_OFF;
         ST_L2_OFF:    st_d = ST_RET_OFF;
         ST_RET_OFF:   st_d = ST_BANK_OFF;
         ST_BANK_OFF: begin
            bank_clr_o  = 1'b1;
            tmr_start_o = 1'b1;
            tmr_len_o   = CW'(BANK_WAIT);
            st_d        = ST_BANK_WAIT;
         end
         ST_BANK_WAIT:
            if (tmr_done_i) st_d = (bank_idx_o == LAST_BANK) ? ST_MEM_CLAMP : ST_BANK_OFF;
         ST_MEM_CLAMP: st_d = ST_HSW_OFF;
         ST_HSW_OFF: begin
            tmr_start_o = 1'b1;
            tmr_len_o   = CW'(SETTLE_WAIT);
            st_d        = ST_SETTLE;
         end
         ST_SETTLE:    if (tmr_done_i) st_d = ST_POLL;
         ST_POLL: begin
            if (!hsw_ack_i)                st_d = ST_SUB_RST;
            else if (polls_q == LAST_POLL) st_d = ST_FAIL;
            else begin
               tmr_start_o = 1'b1;
               tmr_len_o   = CW'(POLL_GAP);
               st_d        = ST_POLL_WAIT;
            end
         end
         ST_POLL_WAIT: if (tmr_done_i) st_d = ST_POLL;
         ST_SUB_RST:   st_d = ST_CORE_RST;
         ST_CORE_RST:  st_d = ST_DONE;
         default:      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         polls_q       <= '0;
         bank_idx_o    <= '0;
         core_clk_en_o <= 1'b1;
         io_clamp_o    <= 1'b0;
         l2_stby_n_o   <= 1'b1;
         slp_ret_n_o   <= 1'b1;
         mem_clamp_o   <= 1'b0;
         head_sw_on_o  <= 1'b1;
         sub_rst_o     <= 1'b0;
         core_rst_o    <= 1'b0;
         warn_o        <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            polls_q    <= '0;
            bank_idx_o <= '0;
         end
         case (st_q)
            ST_HALT:      if (halt_ack_i && !halt_idle_i) warn_o <= 1'b1;
            ST_CLK_OFF:   core_clk_en_o <= 1'b0;
            ST_IO_CLAMP:  io_clamp_o    <= 1'b1;
            ST_L2_OFF:    l2_stby_n_o   <= 1'b0;
            ST_RET_OFF:   slp_ret_n_o   <= 1'b0;
            ST_BANK_WAIT:
               if (tmr_done_i && bank_idx_o != LAST_BANK) bank_idx_o <= bank_idx_o + 1'b1;
            ST_MEM_CLAMP: mem_clamp_o   <= 1'b1;
            ST_HSW_OFF:   head_sw_on_o  <= 1'b0;
            ST_POLL:
               if (hsw_ack_i && polls_q != LAST_POLL) polls_q <= polls_q + 1'b1;
            ST_SUB_RST:   sub_rst_o     <= 1'b1;
            ST_CORE_RST:  core_rst_o    <= 1'b1;
            default: ;
         endcase
      end
   end

   assign halt_req_o = (st_q == ST_HALT);
   assign done_o     = (st_q == ST_DONE);
   assign err_o      = (st_q == ST_FAIL);

   AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      polls_q <= LAST_POLL); // R6
   AST_BUSY_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !halt_req_o && !done_o && !err_o && st_q != ST_IDLE) |=> !halt_req_o); // R9
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
   import pwrdn_seq_pkg::*;
#(
   parameter int NUM_BANKS   = 20,
   parameter int BANK_WAIT   = 100000,
   parameter int SETTLE_WAIT = 100,
   parameter int POLL_GAP    = 100000,
   parameter int POLL_MAX    = 200
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stop_i,
   input  logic                 halt_ack_i,
   input  logic                 halt_idle_i,
   input  logic                 hsw_ack_i,
   output logic                 halt_req_o,
   output logic                 core_clk_en_o,
   output logic                 io_clamp_o,
   output logic                 l2_stby_n_o,
   output logic                 slp_ret_n_o,
   output logic [NUM_BANKS-1:0] bank_pwr_o,
   output logic                 mem_clamp_o,
   output logic                 head_sw_on_o,
   output logic                 sub_rst_o,
   output logic                 core_rst_o,
   output logic                 done_o,
   output logic                 err_o,
   output logic                 warn_o
);
   localparam int unsigned MAXW = max3(BANK_WAIT, SETTLE_WAIT, POLL_GAP);
   localparam int CW = $clog2(MAXW + 1);
   localparam int IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if (NUM_BANKS < 1)   begin : g_bad_nb $error("NUM_BANKS must be at least 1"); end
   if (BANK_WAIT < 1)   begin : g_bad_bw $error("BANK_WAIT must be at least 1"); end
   if (SETTLE_WAIT < 1) begin : g_bad_sw $error("SETTLE_WAIT must be at least 1"); end
   if (POLL_GAP < 1)    begin : g_bad_pg $error("POLL_GAP must be at least 1"); end
   if (POLL_MAX < 1)    begin : g_bad_pm $error("POLL_MAX must be at least 1"); end

   logic          tmr_start, tmr_done, bank_clr;
   logic [CW-1:0] tmr_len;
   logic [IW-1:0] bank_idx;

   pwrdn_seq_ctrl #(
      .NUM_BANKS(NUM_BANKS), .BANK_WAIT(BANK_WAIT), .SETTLE_WAIT(SETTLE_WAIT),
      .POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX), .CW(CW), .IW(IW)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i),
      .halt_ack_i(halt_ack_i), .halt_idle_i(halt_idle_i), .hsw_ack_i(hsw_ack_i),
      .tmr_done_i(tmr_done), .tmr_start_o(tmr_start), .tmr_len_o(tmr_len),
      .bank_clr_o(bank_clr), .bank_idx_o(bank_idx),
      .halt_req_o(halt_req_o), .core_clk_en_o(core_clk_en_o), .io_clamp_o(io_clamp_o),
      .l2_stby_n_o(l2_stby_n_o), .slp_ret_n_o(slp_ret_n_o), .mem_clamp_o(mem_clamp_o),
      .head_sw_on_o(head_sw_on_o), .sub_rst_o(sub_rst_o), .core_rst_o(core_rst_o),
      .done_o(done_o), .err_o(err_o), .warn_o(warn_o)
   );

   pwrdn_seq_timer #(.CW(CW)) timer_i (
      .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .len_i(tmr_len), .done_o(tmr_done)
   );

   pwrdn_seq_banks #(.NB(NUM_BANKS), .IW(IW)) banks_i (
      .clk(clk), .rst_n(rst_n), .clr_i(bank_clr), .idx_i(bank_idx), .bank_o(bank_pwr_o)
   );

   AST_HALT_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req_o && !halt_ack_i) |=> halt_req_o); // R1
   AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(warn_o) |-> warn_o); // R2
   AST_CLK_OFF_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_en_o) |-> (!halt_req_o && bank_pwr_o == '1)); // R3
   AST_CLAMP_AFTER_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_clamp_o) |-> (bank_pwr_o == '0 && head_sw_on_o)); // R5
   AST_SUB_RST_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sub_rst_o) |-> ($past(hsw_ack_i, 2) == 1'b0 && !head_sw_on_o)); // R6
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R7
   AST_FAIL_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> !sub_rst_o); // R7
   AST_RST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_o) |-> (sub_rst_o && $past(sub_rst_o))); // R8
endmodule

// File: tb/pwrdn_seq_tb_top.sv
module pwrdn_seq_tb_top;
   localparam int NB = 4;
   localparam int BW = 3;
   localparam int SW = 2;
   localparam int PG = 2;
   localparam int PM = 3;
   localparam int HD = 2;
   localparam int LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_i = 1'b0;
   logic halt_ack_i = 1'b0;
   logic halt_idle_i = 1'b1;
   logic hsw_ack_i = 1'b0;
   logic halt_req_o, core_clk_en_o, io_clamp_o, l2_stby_n_o, slp_ret_n_o;
   logic [NB-1:0] bank_pwr_o;
   logic mem_clamp_o, head_sw_on_o, sub_rst_o, core_rst_o, done_o, err_o, warn_o;

   always #5 clk = ~clk;

   pwrdn_seq #(.NUM_BANKS(NB), .BANK_WAIT(BW), .SETTLE_WAIT(SW),
               .POLL_GAP(PG), .POLL_MAX(PM)) dut_i (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .halt_ack_i(halt_ack_i),
      .halt_idle_i(halt_idle_i), .hsw_ack_i(hsw_ack_i), .halt_req_o(halt_req_o),
      .core_clk_en_o(core_clk_en_o), .io_clamp_o(io_clamp_o), .l2_stby_n_o(l2_stby_n_o),
      .slp_ret_n_o(slp_ret_n_o), .bank_pwr_o(bank_pwr_o), .mem_clamp_o(mem_clamp_o),
      .head_sw_on_o(head_sw_on_o), .sub_rst_o(sub_rst_o), .core_rst_o(core_rst_o),
      .done_o(done_o), .err_o(err_o), .warn_o(warn_o)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   int thr = 0, hcnt = 0, hd = 0;
   int t_hr, t_hf, t_clk, t_io, t_l2, t_ret, t_mc, t_hsw, t_sub, t_core, t_done, t_err, n_hr;
   int t_bank [NB];
   logic p_hreq, p_clk, p_io, p_l2, p_ret, p_mc, p_hsw, p_sub, p_core, p_done, p_err;
   logic [NB-1:0] p_bank;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr_stamps();
      t_hr = -1; t_hf = -1; t_clk = -1; t_io = -1; t_l2 = -1; t_ret = -1; t_mc = -1;
      t_hsw = -1; t_sub = -1; t_core = -1; t_done = -1; t_err = -1; n_hr = 0;
      for (int i = 0; i < NB; i++) t_bank[i] = -1;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > LIMIT) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // edge stamps, halt responder and head-switch status model
   always @(negedge clk) begin
      if (rst_n) begin
         if (halt_req_o && !p_hreq) begin t_hr = cyc; n_hr++; end
         if (!halt_req_o && p_hreq) t_hf = cyc;
         if (!core_clk_en_o && p_clk) t_clk = cyc;
         if (io_clamp_o && !p_io) t_io = cyc;
         if (!l2_stby_n_o && p_l2) t_l2 = cyc;
         if (!slp_ret_n_o && p_ret) t_ret = cyc;
         for (int i = 0; i < NB; i++) if (!bank_pwr_o[i] && p_bank[i]) t_bank[i] = cyc;
         if (mem_clamp_o && !p_mc) t_mc = cyc;
         if (!head_sw_on_o && p_hsw) t_hsw = cyc;
         if (sub_rst_o && !p_sub) t_sub = cyc;
         if (core_rst_o && !p_core) t_core = cyc;
         if (done_o && !p_done) t_done = cyc;
         if (err_o && !p_err) t_err = cyc;
      end
      p_hreq = halt_req_o; p_clk = core_clk_en_o; p_io = io_clamp_o; p_l2 = l2_stby_n_o;
      p_ret = slp_ret_n_o; p_bank = bank_pwr_o; p_mc = mem_clamp_o; p_hsw = head_sw_on_o;
      p_sub = sub_rst_o; p_core = core_rst_o; p_done = done_o; p_err = err_o;
      if (halt_req_o) begin hd++; if (hd >= HD) halt_ack_i = 1'b1; end
      else begin hd = 0; halt_ack_i = 1'b0; end
      if (!head_sw_on_o) hcnt++; else hcnt = 0;
      hsw_ack_i = (hcnt < thr);
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
   endtask

   task automatic pulse_stop(output int s);
      @(negedge clk); stop_i = 1'b1; s = cyc;
      @(negedge clk); stop_i = 1'b0; #1;
   endtask

   task automatic wait_end();
      while (!(done_o || err_o)) @(negedge clk);
      #1;
   endtask

   localparam int LASTOFS = SW + (PG + 1) * (PM - 1);

   initial begin
      int s, s2;
      clr_stamps();
      do_reset();
      // R11 reset values
      chk("R11 halt_req", halt_req_o, 0);
      chk("R11 clk/l2/ret/head on", {core_clk_en_o, l2_stby_n_o, slp_ret_n_o, head_sw_on_o}, 4'hF);
      chk("R11 banks on", bank_pwr_o, {NB{1'b1}});
      chk("R11 clamps/resets/flags",
          {io_clamp_o, mem_clamp_o, sub_rst_o, core_rst_o, done_o, err_o, warn_o}, 0);

      // Run A: acknowledge clears at once, port idle, stray stop mid-sequence
      thr = 0; halt_idle_i = 1'b1; clr_stamps();
      pulse_stop(s);
      while (t_bank[1] < 0) @(negedge clk);
      pulse_stop(s2);
      wait_end();
      chk("R1 req after stop", t_hr - s, 1);
      chk("R1 req held until ack", t_hf - t_hr, HD);
      chk("R3 clk off", t_clk - t_hr, HD + 1);
      chk("R3 io clamp", t_io - t_clk, 1);
      chk("R3 l2 standby", t_l2 - t_io, 1);
      chk("R3 sleep ret", t_ret - t_l2, 1);
      chk("R4 bank0", t_bank[0] - t_ret, 1);
      for (int i = 1; i < NB; i++) chk("R4 bank gap", t_bank[i] - t_bank[i-1], BW + 1);
      chk("R5 mem clamp", t_mc - t_bank[NB-1], BW + 1);
      chk("R5 head switch", t_hsw - t_mc, 1);
      chk("R6 first poll clears", t_sub - t_hsw, SW + 2);
      chk("R8 core reset", t_core - t_sub, 1);
      chk("R8 done", t_done - t_core, 0);
      chk("R9 single halt request", n_hr, 1);
      chk("R9 timing unchanged", t_done - t_hr, HD + 1 + 4 + NB * (BW + 1) + 1 + SW + 3);
      chk("R2 no warn when idle", warn_o, 0);

      // R10 restart from done
      clr_stamps();
      pulse_stop(s);
      chk("R10 done cleared", done_o, 0);
      chk("R10 halt req", halt_req_o, 1);
      wait_end();
      chk("R10 second run done", {done_o, sub_rst_o, core_rst_o, err_o}, 4'b1110);

      // Run B: port not idle, acknowledge clears at the last poll
      do_reset();
      thr = LASTOFS + 1; halt_idle_i = 1'b0; clr_stamps();
      pulse_stop(s);
      wait_end();
      halt_idle_i = 1'b1;
      chk("R2 sequence continues", t_clk - t_hr, HD + 1);
      chk("R2 warn set", warn_o, 1);
      chk("R6 last poll clears", t_sub - t_hsw, LASTOFS + 2);
      chk("R7 success no err", {done_o, err_o}, 2'b10);
      repeat (5) @(negedge clk); #1;
      chk("R2 warn sticky", warn_o, 1);

      // Run C: acknowledge never clears within the limit
      do_reset();
      thr = LASTOFS + 2; clr_stamps();
      pulse_stop(s);
      wait_end();
      chk("R7 err timing", t_err - t_hsw, LASTOFS + 1);
      repeat (8) @(negedge clk); #1;
      chk("R7 no resets or done", {sub_rst_o, core_rst_o, done_o, err_o}, 4'b0001);
      pulse_stop(s);
      chk("R10 restart from error", {err_o, halt_req_o}, 2'b01);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule